// File: doc/BRIEF.md
# Slot-Mapped Audio Receive FIFO

This block sits behind an AC'97 frame deserializer. It picks the words of one time slot, or of two neighbouring slots, out of the incoming slot stream and queues them for a processor. Each 20-bit slot word is cut down to its upper 16 bits before it is stored. In stereo mode the two slots are taken strictly in turn, left first, so that left and right samples alternate in the queue.

A processor sets up the block through one 16-bit control and status word. It takes samples out by reading the data address, and each such read pops one entry. A level interrupt and a DMA request follow the fill level.

The slot stream uses a valid/ready pair, but the block never back-pressures it: `slot_ready` is always high, because a serial link cannot stall. A matching word that finds the queue full is dropped, and the drop is recorded in a sticky overflow flag. Words that do not match are consumed and discarded.

Top module: `audio_slot_rx_fifo`

## Requirements
- R1: After reset every stored control field and the overflow flag are zero, so a control read returns 16'h4000 (only the empty flag set), and `irq` and `dma_req` are low.
- R2: Words are accepted only while connection bits [1:0] equal 2'b10. With codes 00, 01 or 11 every slot word is ignored.
- R3: Bits [7:4] select the slot and bit 3 selects stereo (1) or mono (0). Mono accepts `slot_num` equal to the selection for selections 3 to 12. Stereo accepts the selection and the selection plus one for selections 3 to 11. Any other selection accepts nothing.
- R4: An accepted word stores `slot_data[19:4]`. A read with `reg_addr`=1 returns the oldest entry and removes it. `reg_addr`=0 is the control/status word.
- R5: In stereo mode the block expects the lower slot first. It toggles its expectation on every matching word it takes and drops a word from the other slot. Any control write resets the expectation to the lower slot.
- R6: `irq` is high exactly while the fill level is at least bits [10:8] plus one.
- R7: Read-only bit 13 is set while 8 words are held, and read-only bit 14 is set while none are held.
- R8: A matching word that arrives while the queue is full, with no pop in the same cycle, is discarded and sets overflow bit 15. The stored contents are left unchanged.
- R9: Writing the control word with bit 15 set clears the overflow flag. Writing it with bit 15 clear leaves the flag as it is. An overflow in the same cycle as a clear wins.
- R10: A data read while the queue is empty returns zero and removes nothing.
- R11: `dma_req` is high exactly while DMA enable bit 11 is set and the queue is not empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slot_valid | input | 1 | Slot word present |
| slot_ready | output | 1 | Always high; the stream is never stalled |
| slot_num | input | 4 | Slot number of the present word |
| slot_data | input | 20 | Slot word |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops on data address) |
| reg_addr | input | 1 | 0 = control/status, 1 = data |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, combinational from current state |
| irq | output | 1 | Level interrupt on fill threshold |
| dma_req | output | 1 | DMA request |

## Verification
The hardest states to reach are the stereo pairing states. The expectation flag cannot be seen at the ports, so the bench infers it from which out-of-order words are dropped. It sends sequences with repeated left or right slots and a control write between a left and a right word, and then reads back the exact order that was stored. The overflow-versus-clear collision also needs a full queue, a matching word and a control write with bit 15 all in one cycle, and the bench drives them together on purpose.

// File: rtl/audio_rx_pkg.sv
package audio_rx_pkg;
  localparam logic [1:0] CONN_ON  = 2'b10;
  localparam logic [3:0] SLOT_LO  = 4'd3;
  localparam logic [3:0] SLOT_HI  = 4'd12;

  typedef struct packed {
    logic       dma_en;
    logic [2:0] thr;
    logic [3:0] slot;
    logic       stereo;
    logic [1:0] conn;
  } rx_cfg_t;
endpackage

// File: rtl/audio_rx_ctrl_reg.sv
module audio_rx_ctrl_reg
  import audio_rx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [15:0] wdata,
  input  logic        ovf_set,
  output rx_cfg_t     cfg,
  output logic        ovf
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '0;
    end else if (wr_en) begin
      cfg.conn   <= wdata[1:0];
      cfg.stereo <= wdata[3];
      cfg.slot   <= wdata[7:4];
      cfg.thr    <= wdata[10:8];
      cfg.dma_en <= wdata[11];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                ovf <= 1'b0;
    else if (ovf_set)          ovf <= 1'b1;
    else if (wr_en && wdata[15]) ovf <= 1'b0;
  end
endmodule

// File: rtl/audio_rx_slot_match.sv
module audio_rx_slot_match
  import audio_rx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  rx_cfg_t    cfg,
  input  logic       cfg_wr,
  input  logic       in_valid,
  input  logic [3:0] in_slot,
  output logic       hit
);
  logic right_q;
  logic sel_ok;
  logic [3:0] want;

  always_comb begin
    if (cfg.stereo) begin
      sel_ok = (cfg.slot >= SLOT_LO) && (cfg.slot < SLOT_HI);
      want   = right_q ? cfg.slot + 4'd1 : cfg.slot;
    end else begin
      sel_ok = (cfg.slot >= SLOT_LO) && (cfg.slot <= SLOT_HI);
      want   = cfg.slot;
    end
    hit = in_valid && (cfg.conn == CONN_ON) && sel_ok && (in_slot == want);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   right_q <= 1'b0;
    else if (cfg_wr)              right_q <= 1'b0;
    else if (hit && cfg.stereo)   right_q <= ~right_q;
  end
endmodule

// File: rtl/audio_rx_fifo_store.sv
module audio_rx_fifo_store #(
  parameter int DEPTH = 8,
  parameter int WIDTH = 16
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push_req,
  input  logic [WIDTH-1:0]             push_data,
  input  logic                         pop_req,
  output logic [WIDTH-1:0]             head,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         full,
  output logic                         empty,
  output logic                         push,
  output logic                         pop,
  output logic                         lost
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH-1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0] wp, rp;

  assign full  = (count == CW'(DEPTH));
  assign empty = (count == '0);
  assign pop   = pop_req && !empty;
  assign push  = push_req && (!full || pop);
  assign lost  = push_req && full && !pop;
  assign head  = mem[rp];

  always_ff @(posedge clk) begin
    if (push) mem[wp] <= push_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0;
      rp <= '0;
      count <= '0;
    end else begin
      if (push) wp <= (wp == LAST) ? '0 : wp + AW'(1);
      if (pop)  rp <= (rp == LAST) ? '0 : rp + AW'(1);
      case ({push, pop})
        2'b10:   count <= count + CW'(1);
        2'b01:   count <= count - CW'(1);
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/audio_slot_rx_fifo.sv
module audio_slot_rx_fifo
  import audio_rx_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int WIDTH  = 16,
  parameter int SLOT_W = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              slot_valid,
  output logic              slot_ready,
  input  logic [3:0]        slot_num,
  input  logic [SLOT_W-1:0] slot_data,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic              reg_addr,
  input  logic [15:0]       reg_wdata,
  output logic [15:0]       reg_rdata,
  output logic              irq,
  output logic              dma_req
);
  localparam int CW = $clog2(DEPTH+1);

  rx_cfg_t          cfg;
  logic             ovf_flag, ctrl_wr, slot_hit, rd_pop_req;
  logic             fifo_push, fifo_pop, fifo_full, fifo_empty, fifo_lost;
  logic [WIDTH-1:0] fifo_head;
  logic [CW-1:0]    fifo_count;

  assign slot_ready = 1'b1;
  assign ctrl_wr    = reg_wr && !reg_addr;
  assign rd_pop_req = reg_rd && reg_addr;

  audio_rx_ctrl_reg u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(ctrl_wr), .wdata(reg_wdata),
    .ovf_set(fifo_lost), .cfg(cfg), .ovf(ovf_flag)
  );

  audio_rx_slot_match u_match (
    .clk(clk), .rst_n(rst_n), .cfg(cfg), .cfg_wr(ctrl_wr),
    .in_valid(slot_valid), .in_slot(slot_num), .hit(slot_hit)
  );

  audio_rx_fifo_store #(.DEPTH(DEPTH), .WIDTH(WIDTH)) u_store (
    .clk(clk), .rst_n(rst_n), .push_req(slot_hit),
    .push_data(slot_data[SLOT_W-1 -: WIDTH]), .pop_req(rd_pop_req),
    .head(fifo_head), .count(fifo_count), .full(fifo_full),
    .empty(fifo_empty), .push(fifo_push), .pop(fifo_pop), .lost(fifo_lost)
  );

  always_comb begin
    if (reg_addr) reg_rdata = fifo_empty ? '0 : fifo_head;
    else reg_rdata = {ovf_flag, fifo_empty, fifo_full, 1'b0, cfg.dma_en,
                      cfg.thr, cfg.slot, cfg.stereo, 1'b0, cfg.conn};
  end

  assign irq     = fifo_count > CW'(cfg.thr);
  assign dma_req = cfg.dma_en && !fifo_empty;
endmodule

// File: rtl/audio_rx_fifo_checker.sv
module audio_rx_fifo_checker #(
  parameter int DEPTH = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       hit,
  input logic                       push,
  input logic                       pop,
  input logic                       pop_req,
  input logic                       full,
  input logic                       empty,
  input logic [$clog2(DEPTH+1)-1:0] count,
  input logic                       ovf,
  input logic [1:0]                 conn,
  input logic                       irq,
  input logic                       cfg_wr
);
  localparam int CW = $clog2(DEPTH+1);

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH)); // R7
  AST_OVF_ON_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
    full && hit && !pop |=> ovf); // R8
  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    full && !pop |=> full); // R8
  AST_EMPTY_READ_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    empty && pop_req && !hit |=> empty); // R10
  AST_DISCONNECTED_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    conn != 2'b10 && !pop |=> $stable(count)); // R2
  AST_IRQ_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(push) || $past(cfg_wr)); // R6
endmodule

bind audio_slot_rx_fifo audio_rx_fifo_checker #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .hit(slot_hit), .push(fifo_push), .pop(fifo_pop),
  .pop_req(rd_pop_req), .full(fifo_full), .empty(fifo_empty),
  .count(fifo_count), .ovf(ovf_flag), .conn(cfg.conn), .irq(irq),
  .cfg_wr(ctrl_wr)
);

// File: tb/test_audio_slot_rx_fifo.sv
module test_audio_slot_rx_fifo;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        slot_valid = 1'b0;
  logic        slot_ready;
  logic [3:0]  slot_num = '0;
  logic [19:0] slot_data = '0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0, reg_addr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        irq, dma_req;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  audio_slot_rx_fifo i_audio_slot_rx_fifo (
    .clk(clk), .rst_n(rst_n), .slot_valid(slot_valid), .slot_ready(slot_ready),
    .slot_num(slot_num), .slot_data(slot_data), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .dma_req(dma_req)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  function automatic logic [15:0] mk(input int conn, input int st, input int sel,
                                     input int thr, input int dma);
    mk = 16'((dma << 11) | (thr << 8) | (sel << 4) | (st << 3) | conn);
  endfunction

  task automatic wr_ctrl(input logic [15:0] v);
    reg_wr = 1'b1; reg_addr = 1'b0; reg_wdata = v;
    cyc();
    reg_wr = 1'b0;
  endtask

  task automatic send(input int n, input logic [15:0] d);
    slot_valid = 1'b1; slot_num = 4'(n); slot_data = {d, 4'hB};
    cyc();
    slot_valid = 1'b0;
  endtask

  task automatic rd_ctrl(output logic [15:0] v);
    reg_addr = 1'b0; #1 v = reg_rdata;
  endtask

  task automatic rd_data(output logic [15:0] v);
    reg_addr = 1'b1; reg_rd = 1'b1; #1 v = reg_rdata;
    cyc();
    reg_rd = 1'b0;
  endtask

  initial begin
    #(20 * 190000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] v, d;
    bit exp_take;
    repeat (3) cyc();
    rst_n = 1'b1;
    cyc();

    // R1 reset state
    rd_ctrl(v);
    check("R1 ctrl after reset", v, 16'h4000);
    check("R1 irq", 16'(irq), 16'h0);
    check("R1 dma_req", 16'(dma_req), 16'h0);
    check("R1 slot_ready", 16'(slot_ready), 16'h1);

    // R2 R3 R4 sweep of connection, mode, selection and incoming slot
    for (int conn = 0; conn < 4; conn++)
      for (int st = 0; st < 2; st++)
        for (int sel = 0; sel < 16; sel++)
          for (int n = 0; n < 16; n++) begin
            wr_ctrl(mk(conn, st, sel, 7, 0));
            d = 16'((sel << 12) | (n << 8) | (conn << 4) | st | 16'h00A0);
            send(n, d);
            exp_take = (conn == 2) && (n == sel) && (sel >= 3) &&
                       (st ? (sel <= 11) : (sel <= 12));
            rd_ctrl(v);
            check("R2 R3 empty flag after word", 16'(v[14]), 16'(!exp_take));
            if (exp_take) begin
              rd_data(v);
              check("R4 stored upper bits", v, d);
            end
          end

    // R5 stereo ordering, selection 5
    wr_ctrl(mk(2, 1, 5, 7, 0));
    send(6, 16'h0BAD); send(5, 16'h1111); send(5, 16'h0BAD);
    send(6, 16'h2222); send(6, 16'h0BAD); send(5, 16'h3333); send(6, 16'h4444);
    rd_data(v); check("R5 order L1", v, 16'h1111);
    rd_data(v); check("R5 order R1", v, 16'h2222);
    rd_data(v); check("R5 order L2", v, 16'h3333);
    rd_data(v); check("R5 order R2", v, 16'h4444);
    rd_ctrl(v); check("R5 drained", 16'(v[14]), 16'h1);
    // R5 control write resets expectation to left
    send(5, 16'h5555);
    wr_ctrl(mk(2, 1, 5, 7, 0));
    send(6, 16'h0BAD); send(5, 16'h6666);
    rd_data(v); check("R5 phase reset first", v, 16'h5555);
    rd_data(v); check("R5 phase reset second", v, 16'h6666);
    rd_ctrl(v); check("R5 phase reset drained", 16'(v[14]), 16'h1);

    // R6 R7 R8 R9 R10 R11 threshold sweep with fill and overflow
    for (int thr = 0; thr < 8; thr++) begin
      wr_ctrl(mk(2, 0, 3, thr, thr & 1) | 16'h8000);
      for (int k = 0; k <= 8; k++) begin
        rd_ctrl(v);
        check("R6 irq level", 16'(irq), 16'(k >= thr + 1));
        check("R7 empty bit", 16'(v[14]), 16'(k == 0));
        check("R7 full bit", 16'(v[13]), 16'(k == 8));
        check("R11 dma_req", 16'(dma_req), 16'((thr & 1) && k > 0));
        if (k < 8) send(3, 16'((thr << 8) | k));
      end
      send(3, 16'hDEAD);
      rd_ctrl(v);
      check("R8 overflow set", 16'(v[15]), 16'h1);
      wr_ctrl(mk(2, 0, 3, thr, thr & 1));
      rd_ctrl(v);
      check("R9 zero write keeps flag", 16'(v[15]), 16'h1);
      for (int k = 0; k < 8; k++) begin
        rd_data(v);
        check("R8 contents unchanged", v, 16'((thr << 8) | k));
      end
      rd_data(v);
      check("R10 empty read zero", v, 16'h0000);
      send(3, 16'h7070);
      rd_data(v);
      check("R10 pointer not moved", v, 16'h7070);
      rd_ctrl(v);
      check("R10 empty after", 16'(v[14]), 16'h1);
      wr_ctrl(mk(2, 0, 3, thr, thr & 1) | 16'h8000);
      rd_ctrl(v);
      check("R9 one write clears", 16'(v[15]), 16'h0);
    end

    // R9 overflow in the same cycle as a clear wins
    wr_ctrl(mk(2, 0, 4, 7, 0));
    for (int k = 0; k < 8; k++) send(4, 16'(k));
    reg_wr = 1'b1; reg_addr = 1'b0; reg_wdata = mk(2, 0, 4, 7, 0) | 16'h8000;
    slot_valid = 1'b1; slot_num = 4'd4; slot_data = 20'hFFFFF;
    cyc();
    reg_wr = 1'b0; slot_valid = 1'b0;
    rd_ctrl(v);
    check("R9 set wins over clear", 16'(v[15]), 16'h1);
    check("R7 still full", 16'(v[13]), 16'h1);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule